// File: doc/BRIEF.md
# Direct-Transfer DMA Request Queue

This block sits between an external requesting device and four DMA channel engines. The device presents a one-cycle request strobe together with a channel select, a transfer mode and a transfer size. The block decodes these fields and checks them against the rules for each channel. It keeps up to four legal requests in arrival order and hands each one to the selected channel over a per-channel valid/ready pair.

Every request the block serves returns a one-cycle acknowledge to the requester, tagged with the channel number. The requester paces itself on these acknowledges once it has four requests in flight. A request that finds the queue full is dropped and sets a sticky overflow flag. A request with an unsupported field combination is refused and sets a sticky illegal-setting flag. Both flags stay set until a clear input is pulsed.

Top module: `dmaq_top`

## Requirements
- R1: After a clock edge with `rst_n` low, the queue is empty, `disp_valid` is 0, `ack_valid` is 0, and both `ovf_flag` and `ill_flag` are 0.
- R2: Accepted requests are dispatched in arrival order. The head request stays on `disp_valid`, `disp_mode` and `disp_size`, unchanged, until the selected channel's `disp_ready` bit is high at a clock edge.
- R3: The queue holds at most 4 requests. A legal request that arrives while 4 are held and no dispatch happens in that cycle is dropped. It is never dispatched, and `ovf_flag` is set on the following cycle.
- R4: A legal request that arrives while 4 are held is accepted if a dispatch frees a slot in the same cycle. In that case `ovf_flag` is not set.
- R5: `req_id` selects the channel: 00 selects channel 0 (`disp_valid` bit 0), 01 selects channel 1 (bit 1), 10 selects channel 2 (bit 2), and 11 selects channel 3 (bit 3). At most one `disp_valid` bit is high at a time.
- R6: For `req_id` not equal to 00, the mode field has no effect: the request is accepted whatever its mode, and `disp_mode` is presented as 00.
- R7: A request with `req_id` 00 and mode 01, 10 or 11 is a normal single-address demand transfer. It is accepted with any size, and its mode and size are passed through unchanged.
- R8: A request with `req_id` 00 and mode 00 selects the data-bus handshake protocol. With size 101 or 110 it is refused: it is not queued, and `ill_flag` is set on the following cycle. With any other size it is accepted.
- R9: For each dispatch (a `disp_valid` bit and the matching `disp_ready` bit high at a clock edge), `ack_valid` is high for exactly the following cycle, and `ack_chan` gives the channel number. No acknowledge is given without a dispatch.
- R10: `ovf_flag` and `ill_flag` stay set until `flag_clr` is high at a clock edge. If a new setting event arrives in the same cycle as the clear, the flag stays set. A refused request never sets `ovf_flag`, even when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_strobe | input | 1 | One-cycle request strobe from the device |
| req_id | input | 2 | Channel select |
| req_mode | input | 2 | Transfer mode (00 selects data-bus handshake on channel 0) |
| req_size | input | 3 | Transfer size code |
| flag_clr | input | 1 | Clears both sticky flags |
| disp_valid | output | 4 | Per-channel dispatch valid, one-hot or zero |
| disp_ready | input | 4 | Per-channel engine ready |
| disp_mode | output | 2 | Mode of the head request |
| disp_size | output | 3 | Size of the head request |
| ack_valid | output | 1 | One-cycle acknowledge to the requester |
| ack_chan | output | 2 | Channel served by the acknowledge |
| ovf_flag | output | 1 | Sticky flag: a request was dropped because the queue was full |
| ill_flag | output | 1 | Sticky flag: a request was refused as an illegal setting |

## Verification
The design samples a request at a rising edge.
- If the queue was empty, the request shows on `disp_valid` just after that same edge.
- A dispatch happens at the first edge where the selected ready bit is high. Its acknowledge appears just after that edge and lasts one cycle.
- Both flags change just after the edge that sampled the offending request.

The bench drives inputs shortly after a rising edge and samples at the falling edge. Its monitor pairs each observed valid-and-ready with the next expected item from the scoreboard. It also expects the acknowledge at the falling edge one cycle later.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
   localparam int unsigned ID_W   = 2;
   localparam int unsigned MODE_W = 2;
   localparam int unsigned SIZE_W = 3;

   // mode code that selects the data-bus handshake protocol on channel 0
   localparam logic [MODE_W-1:0] MODE_HSK   = '0;
   // size codes not supported under the handshake protocol
   localparam logic [SIZE_W-1:0] SIZE_BAD_A = 3'b101;
   localparam logic [SIZE_W-1:0] SIZE_BAD_B = 3'b110;

   typedef struct packed {
      logic [ID_W-1:0]   chan;
      logic [MODE_W-1:0] mode;
      logic [SIZE_W-1:0] size;
   } dq_item_t;

   localparam int unsigned ITEM_W = $bits(dq_item_t);
endpackage

// File: rtl/dmaq_decode.sv
module dmaq_decode
   import dmaq_pkg::*;
(
   input  logic [ID_W-1:0]   id,
   input  logic [MODE_W-1:0] mode,
   input  logic [SIZE_W-1:0] size,
   output logic              legal,
   output dq_item_t          item
);
   logic is_ch0;
   logic hsk_bad;

   always_comb begin
      is_ch0    = (id == '0);
      hsk_bad   = is_ch0 && (mode == MODE_HSK) &&
                  ((size == SIZE_BAD_A) || (size == SIZE_BAD_B));
      legal     = !hsk_bad;
      item.chan = id;
      // channels other than 0 carry no meaningful mode
      item.mode = is_ch0 ? mode : '0;
      item.size = size;
   end
endmodule

// File: rtl/dmaq_fifo.sv
module dmaq_fifo #(
   parameter int unsigned W     = 7,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] count
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("dmaq_fifo: DEPTH must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= nxt(wr_ptr);
         if (pop)  rd_ptr <= nxt(rd_ptr);
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/dmaq_route.sv
module dmaq_route
   import dmaq_pkg::*;
#(
   parameter int unsigned NCH = 4
) (
   input  logic           head_valid,
   input  logic [ID_W-1:0] head_chan,
   input  logic [NCH-1:0] ready,
   output logic [NCH-1:0] valid,
   output logic           fire
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign valid[c] = head_valid && (head_chan == ID_W'(c));
   end

   assign fire = |(valid & ready);
endmodule

// File: rtl/dmaq_flags.sv
module dmaq_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic set_ovf,
   input  logic set_ill,
   output logic ovf,
   output logic ill
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf <= 1'b0;
         ill <= 1'b0;
      end else begin
         // a new event outranks a clear in the same cycle
         ovf <= set_ovf | (ovf & ~clr);
         ill <= set_ill | (ill & ~clr);
      end
   end
endmodule

// File: rtl/dmaq_top.sv
module dmaq_top
   import dmaq_pkg::*;
#(
   parameter int unsigned DEPTH   = 4,
   parameter int unsigned NCH     = 4,
   parameter bit          ACK_REG = 1'b1,
   localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_strobe,
   input  logic [ID_W-1:0]   req_id,
   input  logic [MODE_W-1:0] req_mode,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              flag_clr,
   output logic [NCH-1:0]    disp_valid,
   input  logic [NCH-1:0]    disp_ready,
   output logic [MODE_W-1:0] disp_mode,
   output logic [SIZE_W-1:0] disp_size,
   output logic              ack_valid,
   output logic [ID_W-1:0]   ack_chan,
   output logic              ovf_flag,
   output logic              ill_flag
);
   if (NCH != (1 << ID_W)) begin : g_bad_nch
      $error("dmaq_top: NCH must equal the number of channel codes");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("dmaq_top: DEPTH must be at least 1");
   end

   logic     legal;
   dq_item_t in_item;
   dq_item_t head;
   logic     q_empty, q_full;
   logic [CW-1:0] q_count;
   logic     fire;
   logic     push, drop, reject;

   dmaq_decode u_dec (
      .id    (req_id),
      .mode  (req_mode),
      .size  (req_size),
      .legal (legal),
      .item  (in_item)
   );

   // a slot freed by this cycle's dispatch is usable by this cycle's request
   assign push   = req_strobe && legal && (!q_full || fire);
   assign drop   = req_strobe && legal && q_full && !fire;
   assign reject = req_strobe && !legal;

   dmaq_fifo #(.W(ITEM_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (fire),
      .din   (in_item),
      .dout  (head),
      .empty (q_empty),
      .full  (q_full),
      .count (q_count)
   );

   dmaq_route #(.NCH(NCH)) u_route (
      .head_valid (!q_empty),
      .head_chan  (head.chan),
      .ready      (disp_ready),
      .valid      (disp_valid),
      .fire       (fire)
   );

   assign disp_mode = head.mode;
   assign disp_size = head.size;

   dmaq_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (flag_clr),
      .set_ovf (drop),
      .set_ill (reject),
      .ovf     (ovf_flag),
      .ill     (ill_flag)
   );

   if (ACK_REG) begin : g_ack_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_chan  <= '0;
         end else begin
            ack_valid <= fire;
            if (fire) ack_chan <= head.chan;
         end
      end
   end else begin : g_ack_comb
      assign ack_valid = fire;
      assign ack_chan  = head.chan;
   end
endmodule

// File: rtl/dmaq_chk.sv
module dmaq_chk
   import dmaq_pkg::*;
#(
   parameter int unsigned DEPTH   = 4,
   parameter int unsigned NCH     = 4,
   parameter bit          ACK_REG = 1'b1,
   localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flag_clr,
   input logic [NCH-1:0]    disp_valid,
   input logic [NCH-1:0]    disp_ready,
   input logic [MODE_W-1:0] disp_mode,
   input logic [SIZE_W-1:0] disp_size,
   input logic              ack_valid,
   input logic              ovf_flag,
   input logic              ill_flag,
   input logic [CW-1:0]     q_count
);
   if (NCH < 2) begin : g_bad_nch
      $error("dmaq_chk: NCH must be at least 2");
   end

   logic hs;
   assign hs = |(disp_valid & disp_ready);

   p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(disp_valid));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|disp_valid && !hs) |=>
         (disp_valid == $past(disp_valid)) && $stable(disp_mode) && $stable(disp_size));

   p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(DEPTH));

   p_mode_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|disp_valid[NCH-1:1]) |-> (disp_mode == '0));

   p_no_bad_hsk_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid[0] && disp_mode == MODE_HSK) |->
         (disp_size != SIZE_BAD_A && disp_size != SIZE_BAD_B));

   p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !flag_clr) |=> ovf_flag);

   p_ill_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ill_flag && !flag_clr) |=> ill_flag);

   if (ACK_REG) begin : g_ack_props
      p_ack_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
         hs |=> ack_valid);
      p_no_stray_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !hs |=> !ack_valid);
   end
endmodule

bind dmaq_top dmaq_chk #(.DEPTH(DEPTH), .NCH(NCH), .ACK_REG(ACK_REG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flag_clr   (flag_clr),
   .disp_valid (disp_valid),
   .disp_ready (disp_ready),
   .disp_mode  (disp_mode),
   .disp_size  (disp_size),
   .ack_valid  (ack_valid),
   .ovf_flag   (ovf_flag),
   .ill_flag   (ill_flag),
   .q_count    (q_count)
);

// File: tb/tb_dmaq_top.sv
`timescale 1ns/1ps
module tb_dmaq_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_strobe = 1'b0;
   logic [1:0] req_id = '0;
   logic [1:0] req_mode = '0;
   logic [2:0] req_size = '0;
   logic       flag_clr = 1'b0;
   logic [3:0] disp_valid;
   logic [3:0] disp_ready = '0;
   logic [1:0] disp_mode;
   logic [2:0] disp_size;
   logic       ack_valid;
   logic [1:0] ack_chan;
   logic       ovf_flag, ill_flag;

   int total = 0;
   int bad   = 0;
   logic [6:0] sb[$];          // expected {chan, mode, size}
   logic       exp_ack = 1'b0;
   logic [1:0] exp_ack_ch = '0;

   always #2 clk = ~clk;       // 250 MHz

   dmaq_top dut (
      .clk(clk), .rst_n(rst_n), .req_strobe(req_strobe), .req_id(req_id),
      .req_mode(req_mode), .req_size(req_size), .flag_clr(flag_clr),
      .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_mode(disp_mode),
      .disp_size(disp_size), .ack_valid(ack_valid), .ack_chan(ack_chan),
      .ovf_flag(ovf_flag), .ill_flag(ill_flag)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver: one request, scoreboard entry pushed when acceptance is expected
   task automatic send(input logic [1:0] id, input logic [1:0] md,
                       input logic [2:0] sz, input bit acc, input bit clr = 1'b0);
      @(posedge clk); #1;
      req_strobe = 1'b1; req_id = id; req_mode = md; req_size = sz; flag_clr = clr;
      if (acc) sb.push_back({id, (id == 2'b00) ? md : 2'b00, sz});
      @(posedge clk); #1;
      req_strobe = 1'b0; flag_clr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clear_flags;
      @(posedge clk); #1 flag_clr = 1'b1;
      @(posedge clk); #1 flag_clr = 1'b0;
   endtask

   // monitor: pops expected items on each observed dispatch, checks the ack
   initial begin
      wait (rst_n);
      forever begin
         @(negedge clk);
         if (exp_ack || ack_valid) begin
            chk("R9 ack_valid", ack_valid, exp_ack);
            if (exp_ack) chk("R9 ack_chan", ack_chan, exp_ack_ch);
         end
         exp_ack = 1'b0;
         if (|(disp_valid & disp_ready)) begin
            logic [1:0] ch;
            ch = 2'd0;
            for (int c = 0; c < 4; c++) if (disp_valid[c]) ch = 2'(c);
            chk("R5 onehot", $countones(disp_valid), 1);
            if (sb.size() == 0) begin
               chk("R3 unexpected dispatch", {ch, disp_mode, disp_size}, 0);
            end else begin
               chk("R2 R5 R6 R7 item order", {ch, disp_mode, disp_size}, sb.pop_front());
            end
            exp_ack = 1'b1;
            exp_ack_ch = ch;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3);
      // R1 reset state
      chk("R1 disp_valid", disp_valid, 0);
      chk("R1 ack_valid", ack_valid, 0);
      chk("R1 ovf_flag", ovf_flag, 0);
      chk("R1 ill_flag", ill_flag, 0);
      rst_n = 1'b1;

      // R5 R6 R7: one request per channel, engines ready
      disp_ready = 4'hF;
      send(2'b00, 2'b01, 3'b010, 1);
      send(2'b01, 2'b11, 3'b111, 1);
      send(2'b10, 2'b10, 3'b001, 1);
      send(2'b11, 2'b00, 3'b101, 1);   // mode and size ignored rules off channel 0
      send(2'b00, 2'b11, 3'b110, 1);   // R7 normal mode accepts any size
      idle(4);

      // R8 handshake protocol: 101 and 110 refused, 011 accepted
      send(2'b00, 2'b00, 3'b101, 0);
      chk("R8 ill_flag after 101", ill_flag, 1);
      send(2'b00, 2'b00, 3'b110, 0);
      send(2'b00, 2'b00, 3'b011, 1);
      idle(4);
      chk("R8 refused never queued", sb.size(), 0);
      chk("R10 ovf untouched by refusal", ovf_flag, 0);
      clear_flags();
      chk("R10 ill cleared", ill_flag, 0);

      // R2 R3: stall all engines, fill four, drop the fifth
      disp_ready = 4'h0;
      send(2'b10, 2'b01, 3'b011, 1);
      send(2'b01, 2'b10, 3'b001, 1);
      send(2'b11, 2'b11, 3'b111, 1);
      send(2'b00, 2'b01, 3'b100, 1);
      idle(2);
      chk("R2 head held valid", disp_valid, 4'b0100);
      chk("R2 R6 head mode", disp_mode, 0);
      chk("R2 head size", disp_size, 3);
      chk("R9 no ack while stalled", ack_valid, 0);
      send(2'b01, 2'b00, 3'b010, 0);
      chk("R3 ovf_flag after drop", ovf_flag, 1);
      disp_ready = 4'hF;
      idle(10);
      chk("R3 dropped never dispatched", sb.size(), 0);
      clear_flags();
      chk("R10 ovf cleared", ovf_flag, 0);

      // R4: full queue, a dispatch and a new request in the same cycle
      disp_ready = 4'h0;
      for (int i = 0; i < 4; i++) send(2'b01, 2'b00, 3'(i), 1);
      @(posedge clk); #1;
      disp_ready = 4'b0010;
      req_strobe = 1'b1; req_id = 2'b10; req_mode = 2'b01; req_size = 3'b111;
      sb.push_back({2'b10, 2'b00, 3'b111});
      @(posedge clk); #1;
      req_strobe = 1'b0;
      chk("R4 no overflow on same-cycle free", ovf_flag, 0);
      disp_ready = 4'hF;
      idle(10);
      chk("R4 all delivered", sb.size(), 0);

      // R10: refusal while full sets only ill; clear loses to new event
      disp_ready = 4'h0;
      for (int i = 0; i < 4; i++) send(2'b11, 2'b01, 3'(i + 2), 1);
      send(2'b00, 2'b00, 3'b110, 0);
      chk("R10 ill set while full", ill_flag, 1);
      chk("R10 refusal sets no ovf", ovf_flag, 0);
      send(2'b10, 2'b01, 3'b000, 0, 1'b1);   // overflow with clear in same cycle
      chk("R10 ovf wins over clear", ovf_flag, 1);
      chk("R10 ill cleared by clear", ill_flag, 0);
      disp_ready = 4'hF;
      idle(10);
      chk("R2 queue drained", sb.size(), 0);
      chk("R9 ack idle at end", ack_valid, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule